// File: doc/BRIEF.md
# Hall-Synchronized Quadrature Position Counter

This block keeps a signed rotor position count from an incremental encoder with two phase lines. It also clears that count in hardware whenever the commutation sensor moves to a new sector. The three commutation sensor lines are folded into one parity signal. Every toggle of that parity, in either direction, is one sector event. On an event the running count is copied into a capture register and the counter restarts from zero. No software action is involved.

Between events the counter decodes the two encoder lines at four counts per cycle. A step in the wrong order moves the count down. A sample in which both lines changed together is rejected and flagged. All asynchronous inputs pass through a two-stage synchroniser. A change on any input therefore reaches every output on the third rising clock edge after it is applied.

Top module: `hall_sync_qcount`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `pos_count`, `pos_capture`, `hall_evt`, `quad_err` and `hall_state` to zero.
- R2: With the encoder bits written {A,B}, each forward transition (00→10, 10→11, 11→01, 01→00) raises `pos_count` by one. A change applied to the inputs appears on every output after the third rising edge, and not earlier.
- R3: Each reverse transition (00→01, 01→11, 11→10, 10→00) lowers `pos_count` by one, so counting down from zero gives -1.
- R4: A sector event occurs when the exclusive-OR of the three `hall_in` bits changes. A change of two bits at once leaves the parity alone and is no event. `hall_state` always shows the synchronised `hall_in` value.
- R5: A sector event clears `pos_count` to zero and raises `hall_evt` for exactly one cycle.
- R6: A sector event loads `pos_capture` with the count held just before the clear. At all other times `pos_capture` is unchanged.
- R7: A sample in which A and B both changed (00↔11 or 10↔01) leaves `pos_count` unchanged and raises `quad_err` for one cycle.
- R8: When a sector event and an encoder step arrive in the same cycle, the clear wins. `pos_count` becomes zero and `pos_capture` excludes that step.
- R9: `pos_count` wraps in two's complement at width `CNT_W`. The largest value plus one step gives the most negative value, and one step down gives the largest value back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| hall_in | input | 3 | Commutation sensor lines, asynchronous |
| pos_count | output | CNT_W | Signed position count since the last sector event |
| pos_capture | output | CNT_W | Count held just before the most recent clear |
| hall_evt | output | 1 | One-cycle strobe on each sector event |
| hall_state | output | 3 | Synchronised commutation sensor state |
| quad_err | output | 1 | One-cycle flag for an illegal encoder transition |

## Verification
The encoder is driven through full forward and reverse cycles. One step is timed edge by edge to pin down the three-edge latency. Diagonal jumps check that a bad sample neither counts nor goes unflagged. On the sensor side, a single-bit toggle must clear the count and capture it. A two-bit toggle must update the state and touch nothing else, which checks that the trigger uses parity and not a plain change detect. A step that lands in the same cycle as a sector event shows which of the two wins. A long forward run at a narrow width shows the wrap in both directions.

// File: rtl/hsq_pkg.sv
// Package: shared types and the encoder transition decoder for the
// hall-synchronised position counter.
// Assumes: encoder bits are packed as {A,B}; forward order is 00,10,11,01.
package hsq_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    // Classify one sample-to-sample move of the {A,B} pair.
    function automatic step_e decode_step(input logic [1:0] prev_ab,
                                          input logic [1:0] cur_ab);
        step_e res;
        if (prev_ab == cur_ab) begin
            res = STEP_NONE;
        end else if ((prev_ab ^ cur_ab) == 2'b11) begin
            res = STEP_BAD;
        end else if ((prev_ab == 2'b00 && cur_ab == 2'b10) ||
                     (prev_ab == 2'b10 && cur_ab == 2'b11) ||
                     (prev_ab == 2'b11 && cur_ab == 2'b01) ||
                     (prev_ab == 2'b01 && cur_ab == 2'b00)) begin
            res = STEP_UP;
        end else begin
            res = STEP_DN;
        end
        return res;
    endfunction

endpackage

// File: rtl/hsq_sync.sv
// Module: multi-stage flip-flop synchroniser for a bus of independent bits.
// Assumes: each bit is sampled on its own; there is no bus coherence.
// Reset clears every stage, so the inputs are expected to sit at zero
// while reset is applied.
module hsq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage: capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: let any metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= '0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hsq_quad_dec.sv
// Module: x4 quadrature decoder. It compares the synchronised {A,B} pair
// with the previous sample and reports a step class combinationally.
// It also registers a one-cycle error flag for a diagonal jump.
// Assumes: the inputs are already synchronised to clk.
module hsq_quad_dec
    import hsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_sync,
    output step_e      step,
    output logic       err_q
);
    logic [1:0] ab_prev_q;

    // Classify the current move against the last sample.
    always_comb begin
        step = decode_step(ab_prev_q, ab_sync);
    end

    // Remember the last sample and flag an illegal jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_prev_q <= 2'b00;
            err_q     <= 1'b0;
        end else begin
            ab_prev_q <= ab_sync;
            err_q     <= (step == STEP_BAD);
        end
    end

    AST_ERR_ON_DIAGONAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((ab_sync ^ ab_prev_q) == 2'b11) |=> err_q) else $error("diag"); // R7
endmodule

// File: rtl/hsq_hall_det.sv
// Module: commutation sensor event detector. It folds the three
// synchronised lines into a parity bit. A toggle of that parity is an
// event, given combinationally for the counter and as a registered strobe.
// Assumes: the inputs are already synchronised to clk.
module hsq_hall_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_sync,
    output logic       evt,
    output logic       evt_q,
    output logic [2:0] state_q
);
    logic parity_now;
    logic parity_prev;

    // Fold the sensor lines and compare with the stored parity.
    always_comb begin
        parity_now  = ^hall_sync;
        parity_prev = ^state_q;
        evt         = parity_now ^ parity_prev;
    end

    // Keep the last sensor state and form the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 3'b000;
            evt_q   <= 1'b0;
        end else begin
            state_q <= hall_sync;
            evt_q   <= evt;
        end
    end

    AST_STROBE_MEANS_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> ((^state_q) != (^$past(state_q)))) else $error("par"); // R4
endmodule

// File: rtl/hsq_pos_counter.sv
// Module: signed position counter. It counts up or down on decoded
// encoder steps. A sector event clears it and first copies the old value
// into the capture register. The event takes priority over any step.
// Assumes: step and evt are single-cycle, synchronous to clk.
module hsq_pos_counter
    import hsq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  step_e                   step,
    input  logic                    evt,
    output logic signed [CNT_W-1:0] cnt_q,
    output logic signed [CNT_W-1:0] cap_q
);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    // Update count and capture; a clear beats a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else if (evt) begin
            cap_q <= cnt_q;
            cnt_q <= '0;
        end else begin
            case (step)
                STEP_UP: cnt_q <= cnt_q + ONE;
                STEP_DN: cnt_q <= cnt_q - ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_ZERO_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cnt_q == '0)) else $error("zero"); // R5
    AST_CAPTURE_OLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cap_q == $past(cnt_q))) else $error("cap"); // R6
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap_q)) else $error("hold"); // R6
    AST_BAD_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_BAD && !evt) |=> $stable(cnt_q)) else $error("bad"); // R7
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE ||
                  cnt_q == $past(cnt_q) - ONE)) else $error("step"); // R2
endmodule

// File: rtl/hall_sync_qcount.sv
// Module: top of the hall-synchronised quadrature position counter.
// It synchronises the encoder and sensor lines, decodes x4 steps, detects
// parity toggles of the sensor lines and drives the counter.
// Assumes: all inputs are held at zero while rst_n is low. Every output
// follows an input change on the third rising edge.
module hall_sync_qcount
    import hsq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic [2:0]              hall_in,
    output logic signed [CNT_W-1:0] pos_count,
    output logic signed [CNT_W-1:0] pos_capture,
    output logic                    hall_evt,
    output logic [2:0]              hall_state,
    output logic                    quad_err
);
    logic [1:0] ab_sync;
    logic [2:0] hall_sync;
    step_e      step;
    logic       evt_now;

    hsq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync_enc (
        .clk(clk), .rst_n(rst_n), .d_async({enc_a, enc_b}), .q_sync(ab_sync)
    );

    hsq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync_hall (
        .clk(clk), .rst_n(rst_n), .d_async(hall_in), .q_sync(hall_sync)
    );

    hsq_quad_dec u_dec (
        .clk(clk), .rst_n(rst_n), .ab_sync(ab_sync), .step(step), .err_q(quad_err)
    );

    hsq_hall_det u_hall (
        .clk(clk), .rst_n(rst_n), .hall_sync(hall_sync), .evt(evt_now),
        .evt_q(hall_evt), .state_q(hall_state)
    );

    hsq_pos_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .evt(evt_now),
        .cnt_q(pos_count), .cap_q(pos_capture)
    );

    AST_EVENT_CLEARS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        hall_evt |-> (pos_count == '0)) else $error("port"); // R5
endmodule

// File: tb/hall_sync_qcount_tb_top.sv
`timescale 1ns/1ps
module hall_sync_qcount_tb_top;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0;
    logic enc_b = 1'b0;
    logic [2:0] hall_in = 3'b000;
    logic signed [TW-1:0] pos_count;
    logic signed [TW-1:0] pos_capture;
    logic hall_evt;
    logic [2:0] hall_state;
    logic quad_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int exp_cnt = 0;
    int exp_cap = 0;
    logic [1:0] ab = 2'b00;

    always #4 clk = ~clk;

    hall_sync_qcount #(.CNT_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .hall_in(hall_in), .pos_count(pos_count), .pos_capture(pos_capture),
        .hall_evt(hall_evt), .hall_state(hall_state), .quad_err(quad_err)
    );

    function automatic int wrapw(input int v);
        logic signed [TW-1:0] t;
        t = v[TW-1:0];
        return int'(t);
    endfunction

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply {A,B} and hall at a falling edge.
    task automatic drive(input logic [1:0] nab, input logic [2:0] nh);
        @(negedge clk);
        enc_a = nab[1];
        enc_b = nab[0];
        hall_in = nh;
        ab = nab;
    endtask

    // Wait until the last change has reached the outputs.
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 count", int'(pos_count), 0);
        check("R1 capture", int'(pos_capture), 0);
        check("R1 strobe", int'(hall_evt), 0);
        check("R1 err", int'(quad_err), 0);
        check("R1 state", int'(hall_state), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_up_latency();
        drive(fwd(ab), hall_in);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 not before third edge", int'(pos_count), 0);
        @(posedge clk);
        @(negedge clk);
        exp_cnt = 1;
        check("R2 third edge", int'(pos_count), exp_cnt);
        for (int i = 0; i < 4; i++) begin
            drive(fwd(ab), hall_in);
            exp_cnt++;
        end
        settle();
        check("R2 forward cycle", int'(pos_count), exp_cnt);
    endtask

    task automatic t_down();
        for (int i = 0; i < 7; i++) begin
            drive(rev(ab), hall_in);
            exp_cnt--;
        end
        settle();
        check("R3 reverse below zero", int'(pos_count), exp_cnt);
        check("R3 no error", int'(quad_err), 0);
    endtask

    task automatic t_illegal();
        drive(ab ^ 2'b11, hall_in);
        settle();
        check("R7 count held", int'(pos_count), exp_cnt);
        check("R7 err pulse", int'(quad_err), 1);
        @(negedge clk);
        check("R7 err one cycle", int'(quad_err), 0);
        drive(fwd(ab), hall_in);
        exp_cnt++;
        settle();
        check("R7 counting resumes", int'(pos_count), exp_cnt);
    endtask

    task automatic t_hall_single();
        exp_cap = exp_cnt;
        drive(ab, 3'b001);
        settle();
        exp_cnt = 0;
        check("R5 cleared", int'(pos_count), 0);
        check("R5 strobe", int'(hall_evt), 1);
        check("R6 capture", int'(pos_capture), exp_cap);
        check("R4 state", int'(hall_state), 1);
        @(negedge clk);
        check("R5 strobe one cycle", int'(hall_evt), 0);
    endtask

    task automatic t_hall_double();
        for (int i = 0; i < 3; i++) begin
            drive(fwd(ab), hall_in);
            exp_cnt++;
        end
        settle();
        drive(ab, 3'b111);
        settle();
        check("R4 two-bit change no clear", int'(pos_count), exp_cnt);
        check("R4 two-bit change no strobe", int'(hall_evt), 0);
        check("R6 capture unchanged", int'(pos_capture), exp_cap);
        check("R4 state follows", int'(hall_state), 7);
    endtask

    task automatic t_priority();
        exp_cap = exp_cnt;
        drive(fwd(ab), 3'b110);
        settle();
        exp_cnt = 0;
        check("R8 clear wins", int'(pos_count), 0);
        check("R8 capture excludes step", int'(pos_capture), exp_cap);
        check("R8 strobe", int'(hall_evt), 1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 127; i++) begin
            drive(fwd(ab), hall_in);
            exp_cnt++;
        end
        settle();
        check("R9 max value", int'(pos_count), 127);
        drive(fwd(ab), hall_in);
        exp_cnt = wrapw(exp_cnt + 1);
        settle();
        check("R9 wrap to min", int'(pos_count), -128);
        drive(rev(ab), hall_in);
        exp_cnt = wrapw(exp_cnt - 1);
        settle();
        check("R9 wrap back to max", int'(pos_count), exp_cnt);
    endtask

    initial begin
        t_reset();
        t_up_latency();
        t_down();
        t_illegal();
        t_hall_single();
        t_hall_double();
        t_priority();
        t_wrap();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule